// File: doc/BRIEF.md
# Mode-Switchable Branch Direction Predictor

This block supplies taken/not-taken guesses to the fetch stage of a small four-stage in-order core. It can work in two ways. In the high-performance mode it is a global-history predictor: an 8-bit shift register of recent branch outcomes is XORed with fetch address bits to pick one of 256 two-bit saturating counters. In the normal and low-power modes the dynamic structures are switched off and every branch is guessed not taken. Software picks the mode by writing a small mode register.

The fetch stage presents a PC with a lookup strobe and gets the guess back in the same cycle. Later, when the branch resolves, the execute stage presents the branch PC and its real outcome. The block then flags a misprediction in that cycle and, if it is allowed to, trains its counter. Up to `DEPTH` branches may be in flight between lookup and resolve, and they resolve in lookup order. While the dynamic predictor is off, the counters and the history do not change, and a gate-enable output goes low so that the table's clock can be stopped.

Top module: `brdir_pred`

## Requirements
- R1: After reset the mode is high-performance (`modeOut` = 2'b00) and `gateEn` is 1. The history is zero and every counter holds 2'b01, so the first lookups predict not taken.
- R2: A write with `modeWrEn` loads the mode register. The codes are 2'b00 high-performance, 2'b01 normal and 2'b10 low-power. The reserved code 2'b11 is stored and reported as 2'b10. A lookup in the same cycle as the write still uses the old mode, and the new mode applies from the next cycle on.
- R3: In the normal or low-power mode, `predTaken` is 0 for every lookup.
- R4: In the high-performance mode, a lookup reads counter number (history XOR `lookupPc[9:2]`). `predTaken` is combinational in the lookup cycle, and it is 1 when that counter is 2 or 3.
- R5: When a branch resolves, its counter is found by XORing the history captured at that branch's lookup with `resolvePc[9:2]`. The counter counts up on a taken outcome and down on a not-taken outcome, stops at 0 and at 3, and holds the new value from the next clock edge.
- R6: Each resolve in the high-performance mode shifts the history left by one and puts the real outcome in bit 0.
- R7: In the normal and low-power modes, neither the counters nor the history change, and `gateEn` is 0.
- R8: A write that moves the mode from normal or low-power to high-performance clears the history, and the counters keep their frozen values. A write of high-performance while already in high-performance leaves the history alone.
- R9: `mispredict` is 1 in a resolve cycle exactly when `resolveTaken` differs from the guess issued at that branch's lookup, in whatever mode was active then. It is 0 when there is no resolve.
- R10: A counter is trained only when the branch was looked up in the high-performance mode and resolves while that mode is still active. A branch looked up in the other modes but resolved in the high-performance mode shifts the history and trains no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A fetch-side branch lookup is presented |
| lookupPc | input | PC_W | PC of the branch being looked up |
| resolveValid | input | 1 | The oldest in-flight branch resolves |
| resolvePc | input | PC_W | PC of the resolving branch |
| resolveTaken | input | 1 | Real outcome of the resolving branch |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrData | input | 2 | Mode code to write |
| predTaken | output | 1 | Guess for the current lookup |
| mispredict | output | 1 | The resolving branch was guessed wrong |
| gateEn | output | 1 | The dynamic table is in use (clock-gate enable) |
| modeOut | output | 2 | Current mode register value |

## Verification
Assertions check several things on every cycle: the mode register never holds the reserved code, and a write lands on the next edge. The guess is forced low in the static modes. The table and the history hold still while the dynamic predictor is off, the history clears on re-entry and takes the outcome into bit 0 on a shift, and a misprediction flag appears only with a resolve. Other behaviour needs a reference model and can only be shown by the bench's scenarios: that the right counter is indexed and trained, that counters saturate, that frozen counters are reused after re-entry, that a branch which changes mode while in flight trains nothing, and that each flag is compared with the guess issued for that branch and not with the current one.

// File: rtl/brdir_pkg.sv
package brdir_pkg;

  typedef enum logic [1:0] {
    MODE_HIGH = 2'b00,
    MODE_NORM = 2'b01,
    MODE_LOW  = 2'b10
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic gsOn;      // dynamic predictor active
    logic histClr;   // clear global history (mode re-entry)
    logic tblUpd;    // resolve may train the table
    logic histShift; // resolve shifts history
    logic push;      // record a lookup
    logic pop;       // retire oldest record
  } ctrl_s;

  function automatic mode_e canonMode(logic [1:0] raw);
    case (raw)
      2'b00:   return MODE_HIGH;
      2'b01:   return MODE_NORM;
      default: return MODE_LOW;   // 2'b11 reserved, folded onto low-power
    endcase
  endfunction

endpackage

// File: rtl/brdir_ctrl.sv
module brdir_ctrl
  import brdir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrEn,
  input  logic [1:0] modeWrData,
  input  logic       lookupValid,
  input  logic       resolveValid,
  output ctrl_s      ctrl,
  output mode_e      modeQ
);

  mode_e wrMode;
  assign wrMode = canonMode(modeWrData);

  always_ff @(posedge clk) begin
    if (!rstN)         modeQ <= MODE_HIGH;
    else if (modeWrEn) modeQ <= wrMode;
  end

  always_comb begin
    ctrl.gsOn      = (modeQ == MODE_HIGH);
    ctrl.histClr   = modeWrEn && (wrMode == MODE_HIGH) && (modeQ != MODE_HIGH);
    ctrl.tblUpd    = resolveValid && (modeQ == MODE_HIGH);
    ctrl.histShift = resolveValid && (modeQ == MODE_HIGH);
    ctrl.push      = lookupValid;
    ctrl.pop       = resolveValid;
  end

  // R2: reserved code never stored
  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeQ != mode_e'(2'b11));

  // R2: a write is visible on the following edge
  p_write_apply_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeWrEn |=> modeQ == canonMode($past(modeWrData)));

  // R7: without a write the mode holds
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !modeWrEn |=> $stable(modeQ));

endmodule

// File: rtl/brdir_dp.sv
module brdir_dp
  import brdir_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_s           ctrl,
  input  logic            lookupValid,
  input  logic [PC_W-1:0] lookupPc,
  input  logic            resolveValid,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken,
  output logic            predTaken,
  output logic            mispredict
);

  localparam int NUM_CTR = 1 << HIST_W;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [NUM_CTR-1:0][1:0]  tbl;
  logic [HIST_W-1:0]        histQ;
  logic [DEPTH-1:0]         fPred, fDyn;
  logic [DEPTH-1:0][HIST_W-1:0] fHist;
  logic [PTR_W-1:0]         wrPtr, rdPtr;

  logic [HIST_W-1:0] lkIdx, updIdx;
  logic [1:0]        curCtr, nxtCtr;
  logic              hPred, hDyn;
  logic              unusedPcBits;

  assign unusedPcBits = ^{lookupPc[PC_W-1:HIST_W+2], lookupPc[1:0],
                          resolvePc[PC_W-1:HIST_W+2], resolvePc[1:0]};

  // lookup
  assign lkIdx     = histQ ^ lookupPc[HIST_W+1:2];
  assign predTaken = lookupValid && ctrl.gsOn && tbl[lkIdx][1];

  // oldest in-flight record
  assign hPred      = fPred[rdPtr];
  assign hDyn       = fDyn[rdPtr];
  assign updIdx     = fHist[rdPtr] ^ resolvePc[HIST_W+1:2];
  assign mispredict = resolveValid && (resolveTaken != hPred);

  assign curCtr = tbl[updIdx];
  always_comb begin
    nxtCtr = curCtr;
    if (resolveTaken && curCtr != 2'b11)       nxtCtr = curCtr + 2'b01;
    else if (!resolveTaken && curCtr != 2'b00) nxtCtr = curCtr - 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        tbl <= {NUM_CTR{2'b01}};
    else if (ctrl.tblUpd && hDyn)     tbl[updIdx] <= nxtCtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               histQ <= '0;
    else if (ctrl.histClr)   histQ <= '0;
    else if (ctrl.histShift) histQ <= {histQ[HIST_W-2:0], resolveTaken};
  end

  // in-order record of issued guesses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fPred <= '0;
      fDyn  <= '0;
      fHist <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctrl.push) begin
        fPred[wrPtr] <= predTaken;
        fDyn[wrPtr]  <= ctrl.gsOn;
        fHist[wrPtr] <= histQ;
        wrPtr        <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      end
      if (ctrl.pop)
        rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
    end
  end

  p_static_pred_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.gsOn |-> !predTaken);

  p_hist_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.gsOn && !ctrl.histClr) |=> $stable(histQ));

  p_tbl_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.gsOn |=> $stable(tbl));

  p_hist_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.histClr |=> histQ == '0);

  p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.histShift |=> histQ[0] == $past(resolveTaken));

  p_mis_resolve_r9: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> resolveValid);

  // R10: untrained table when the record came from a static mode
  p_no_train_r10: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && !hDyn && !ctrl.histClr) |=> $stable(tbl));

endmodule

// File: rtl/brdir_pred.sv
module brdir_pred
  import brdir_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lookupValid,
  input  logic [PC_W-1:0] lookupPc,
  input  logic            resolveValid,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken,
  input  logic            modeWrEn,
  input  logic [1:0]      modeWrData,
  output logic            predTaken,
  output logic            mispredict,
  output logic            gateEn,
  output logic [1:0]      modeOut
);

  ctrl_s ctrl;
  mode_e modeQ;

  brdir_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeWrEn     (modeWrEn),
    .modeWrData   (modeWrData),
    .lookupValid  (lookupValid),
    .resolveValid (resolveValid),
    .ctrl         (ctrl),
    .modeQ        (modeQ)
  );

  brdir_dp #(.PC_W(PC_W), .HIST_W(HIST_W), .DEPTH(DEPTH)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .lookupValid  (lookupValid),
    .lookupPc     (lookupPc),
    .resolveValid (resolveValid),
    .resolvePc    (resolvePc),
    .resolveTaken (resolveTaken),
    .predTaken    (predTaken),
    .mispredict   (mispredict)
  );

  assign gateEn  = ctrl.gsOn;
  assign modeOut = modeQ;

endmodule

// File: tb/sim_brdir_pred.sv
module sim_brdir_pred;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic            rstN = 1'b0;
  logic            lookupValid = 1'b0, resolveValid = 1'b0, resolveTaken = 1'b0;
  logic [PC_W-1:0] lookupPc = '0, resolvePc = '0;
  logic            modeWrEn = 1'b0;
  logic [1:0]      modeWrData = 2'b00;
  logic            predTaken, mispredict, gateEn;
  logic [1:0]      modeOut;

  brdir_pred #(.PC_W(PC_W)) u0 (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupPc(lookupPc),
    .resolveValid(resolveValid), .resolvePc(resolvePc), .resolveTaken(resolveTaken),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .predTaken(predTaken), .mispredict(mispredict),
    .gateEn(gateEn), .modeOut(modeOut)
  );

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  // scoreboard queues (expected outputs)
  bit expPredQ[$];
  bit expMisQ[$];

  // reference model
  logic [1:0] expMode = 2'b00;
  int         mCtr[256];
  logic [7:0] mHist = '0;
  bit         mPredQ[$];
  logic [7:0] mHistQ[$];
  bit         mDynQ[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: called at posedge+2, returns at the next posedge+2
  task automatic step(bit lv, logic [31:0] lpc, bit rv, logic [31:0] rpc, bit rt,
                      bit we, logic [1:0] wd);
    bit isH, p, ep, ed;
    logic [7:0] eh;
    logic [1:0] nm;
    int ix;
    isH = (expMode == 2'b00);
    ep = 1'b0; ed = 1'b0; eh = '0;
    lookupValid = lv; lookupPc = lpc;
    resolveValid = rv; resolvePc = rpc; resolveTaken = rt;
    modeWrEn = we; modeWrData = wd;
    if (rv) begin
      ep = mPredQ.pop_front();
      eh = mHistQ.pop_front();
      ed = mDynQ.pop_front();
      expMisQ.push_back(rt != ep);
    end
    if (lv) begin
      ix = int'(mHist ^ lpc[9:2]);
      p  = isH && (mCtr[ix] >= 2);
      expPredQ.push_back(p);
      mPredQ.push_back(p);
      mHistQ.push_back(mHist);
      mDynQ.push_back(isH);
    end
    @(posedge clk); #2;
    if (rv && isH) begin
      if (ed) begin
        ix = int'(eh ^ rpc[9:2]);
        if (rt && mCtr[ix] < 3) mCtr[ix]++;
        else if (!rt && mCtr[ix] > 0) mCtr[ix]--;
      end
      mHist = {mHist[6:0], rt};
    end
    if (we) begin
      nm = (wd == 2'b11) ? 2'b10 : wd;
      if (nm == 2'b00 && expMode != 2'b00) mHist = '0;
      expMode = nm;
    end
    lookupValid = 1'b0; resolveValid = 1'b0; modeWrEn = 1'b0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 2'b00);
  endtask

  task automatic setMode(logic [1:0] wd);
    step(0, 0, 0, 0, 0, 1, wd);
  endtask

  // lookup then resolve one branch on its own
  task automatic single(logic [31:0] pc, bit rt);
    step(1, pc, 0, 0, 0, 0, 2'b00);
    step(0, 0, 1, pc, rt, 0, 2'b00);
  endtask

  // monitor: compares at the falling edge
  bit monE;
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(modeOut == expMode, "R2", "modeOut", modeOut, expMode);
      check(gateEn == (expMode == 2'b00), "R7", "gateEn", gateEn, expMode == 2'b00);
      if (lookupValid) begin
        if (expPredQ.size() == 0) check(0, "R4", "unexpected lookup", 1, 0);
        else begin
          monE = expPredQ.pop_front();
          check(predTaken == monE, "R3 R4", "predTaken", predTaken, monE);
        end
      end
      if (resolveValid) begin
        if (expMisQ.size() == 0) check(0, "R9", "unexpected resolve", 1, 0);
        else begin
          monE = expMisQ.pop_front();
          check(mispredict == monE, "R9 R5", "mispredict", mispredict, monE);
        end
      end else begin
        check(!mispredict, "R9", "mispredict idle", mispredict, 0);
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 100000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] prevPc;
    bit prevOut;
    foreach (mCtr[i]) mCtr[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;

    // R1: reset state
    check(modeOut == 2'b00, "R1", "modeOut after reset", modeOut, 0);
    check(gateEn == 1'b1, "R1", "gateEn after reset", gateEn, 1);
    single(32'h0000_0100, 1);   // weakly not taken -> guess 0, flagged

    // R4 R5 R6: overlapped mixed pattern over three PCs
    prevPc = '0; prevOut = 0;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] pc;
      bit out;
      pc  = 32'h0000_1000 + 32'(i % 3) * 4;
      out = (i % 4) != 3;
      step(1, pc, i > 0, prevPc, prevOut, 0, 2'b00);
      prevPc = pc; prevOut = out;
    end
    step(0, 0, 1, prevPc, prevOut, 0, 2'b00);

    // R5: saturation at 3 then walk down toward 0
    for (int i = 0; i < 12; i++) single(32'h0000_0040, 1);
    for (int i = 0; i < 5; i++)  single(32'h0000_0040, 0);
    for (int i = 0; i < 4; i++)  single(32'h0000_0044, 1);

    // R2: lookup in the write cycle uses the old mode
    step(1, 32'h0000_0044, 0, 0, 0, 1, 2'b01);
    // R3 R7 R9: normal mode, frozen table, flagged wrong guesses
    step(1, 32'h0000_0048, 1, 32'h0000_0044, 1, 0, 2'b00);
    step(0, 0, 1, 32'h0000_0048, 1, 0, 2'b00);
    for (int i = 0; i < 6; i++) single(32'h0000_0040 + 32'(i) * 4, i[0]);

    // R10: looked up in normal mode, resolved after return to high mode
    step(1, 32'h0000_0044, 0, 0, 0, 0, 2'b00);
    setMode(2'b00);             // R8: history cleared here
    step(0, 0, 1, 32'h0000_0044, 0, 0, 2'b00);
    for (int i = 0; i < 4; i++) single(32'h0000_0044, 1);

    // R2: low-power and the reserved code
    setMode(2'b10);
    single(32'h0000_0040, 1);
    setMode(2'b11);             // reads back as 2'b10
    single(32'h0000_1004, 0);
    idle();

    // R8: re-entry uses frozen counters with cleared history
    setMode(2'b00);
    single(32'h0000_0040, 1);
    single(32'h0000_1000, 1);

    // R8: rewriting high mode keeps history
    single(32'h0000_0044, 1);
    setMode(2'b00);
    single(32'h0000_0044, 1);
    single(32'h0000_1008, 0);
    idle();

    check(expPredQ.size() == 0, "R4", "pending lookups", expPredQ.size(), 0);
    check(expMisQ.size() == 0, "R9", "pending resolves", expMisQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule